// File: doc/BRIEF.md
# Seven-Line Multiplexed GPIO Bank with Edge Interrupts

This block runs seven pad lines, numbered 0 to 6. Each pad either acts as a plain general-purpose line or carries an alternate function. A pair of pad-select registers makes the choice. In GPIO mode the line has its own direction, drive value, pull and open-drain settings. It can raise a sticky, maskable interrupt on a rising edge, a falling edge or both edges. In alternate mode the GPIO control registers are bypassed. A second set of pull and open-drain registers then applies, and the pad is driven either by an external alternate-function port or by one of three regulator-enable signals.

Each pad input passes through a synchronizer before edge detection. A qualified edge on a line sets that line's status bit and also produces a one-cycle wake-up pulse. Lines 2 and 4 cannot wake the system while the device-off input is asserted. All configuration goes through a small byte-wide register port. Pad drive, pull and interrupt outputs are registered.

Top module: `gpio_mux_bank`

## Requirements
- R1: After a synchronous reset every register reads 0, all pads are in GPIO mode as inputs (pad_oe = 0, no pulls), and irq_o and wake_o are low.
- R2: Register map (5-bit address, bits above 6 read 0): 0x00 direction (1 = output), 0x01 drive value, 0x02 synchronized input (read-only), 0x03 pull enable, 0x04 pull select (1 = up), 0x05 open-drain, 0x06 rising-edge enable, 0x07 falling-edge enable, 0x08 interrupt mask (1 = masked), 0x09 interrupt status, 0x0A pad select for lines 0-3 in bits 3:0, 0x0B pad select for lines 4-6 in bits 2:0 (1 = alternate), 0x0C alternate pull enable, 0x0D alternate pull select, 0x0E alternate open-drain, 0x0F routing (bit0: regulator A on line 3 instead of 0; bit1: regulator C on line 6 instead of 5; bit2: regulator B on line 4). Addresses 0x10-0x1F read 0 and ignore writes. Read data appears one cycle after the address.
- R3: Pad inputs pass through two flops. Address 0x02 shows the synchronized value. Every input transition on a GPIO-mode line gives at most one edge event.
- R4: A line's rising-edge and falling-edge enables select rise, fall, both or no trigger.
- R5: Status bits are sticky. Writing 1 to a bit of 0x09 clears it. Writing 0 leaves it unchanged.
- R6: irq_o is the registered OR of status bits whose mask bit is 0.
- R7: In GPIO mode an output line drives its drive value, or, when open-drain, drives 0 with pad_oe = NOT value. pad_pu/pad_pd follow pull enable and pull select.
- R8: In alternate mode the GPIO direction, value and pull registers have no effect. The pad takes alt_out_i/alt_oe_i under the alternate pull and open-drain registers. alt_in_o shows the synchronized input for alternate lines and 0 for the others.
- R9: Regulator A drives line 0 or line 3, regulator C drives line 5 or line 6, and regulator B drives line 4 when enabled. Each applies only when its line is in alternate mode, and the line is then always output-enabled (unless open-drain).
- R10: Alternate-mode lines raise no status bit. Switching a pad back to GPIO mode creates no edge, whatever level the input sits at.
- R11: Every edge event produces a one-cycle wake_o pulse. While dev_off_i is high, events on lines 2 and 4 produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Registered read data |
| pad_i | input | 7 | Pad input levels |
| pad_o | output | 7 | Pad output values |
| pad_oe | output | 7 | Pad output enables |
| pad_pu | output | 7 | Pull-up enables |
| pad_pd | output | 7 | Pull-down enables |
| alt_out_i | input | 7 | Alternate-function output values |
| alt_oe_i | input | 7 | Alternate-function output enables |
| alt_in_o | output | 7 | Synchronized input for alternate-mode lines |
| regen_a_i | input | 1 | Regulator enable A (line 0 or 3) |
| regen_b_i | input | 1 | Regulator enable B (line 4) |
| regen_c_i | input | 1 | Regulator enable C (line 5 or 6) |
| dev_off_i | input | 1 | Device in off state |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up pulse |

## Verification
Several properties are checked on every cycle. A status bit never rises on a line that was in alternate mode, a status bit only appears after an event, and an edge never repeats in the next cycle. A fully masked bank keeps irq_o low, and while the device is off a wake pulse always traces back to a non-excluded line. Regulator A on line 0 is also watched every cycle. Only the bench scenarios can show the full trigger-mode sweep across all lines, the register decode including unmapped addresses, the drive and pull encodings in both modes, and the absence of a false edge when a held-high line returns to GPIO mode.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NL = 7;
  localparam int SEL_SPLIT = 4;

  localparam logic [4:0] A_DIR   = 5'h00;
  localparam logic [4:0] A_DOUT  = 5'h01;
  localparam logic [4:0] A_DIN   = 5'h02;
  localparam logic [4:0] A_PEN   = 5'h03;
  localparam logic [4:0] A_PSEL  = 5'h04;
  localparam logic [4:0] A_OD    = 5'h05;
  localparam logic [4:0] A_REN   = 5'h06;
  localparam logic [4:0] A_FEN   = 5'h07;
  localparam logic [4:0] A_MASK  = 5'h08;
  localparam logic [4:0] A_STAT  = 5'h09;
  localparam logic [4:0] A_SELLO = 5'h0A;
  localparam logic [4:0] A_SELHI = 5'h0B;
  localparam logic [4:0] A_APEN  = 5'h0C;
  localparam logic [4:0] A_APSEL = 5'h0D;
  localparam logic [4:0] A_AOD   = 5'h0E;
  localparam logic [4:0] A_ROUTE = 5'h0F;

  localparam logic [NL-1:0] WAKE_EXCL = 7'b0010100;

  localparam int REGA_L0 = 0;
  localparam int REGA_L1 = 3;
  localparam int REGB_L  = 4;
  localparam int REGC_L0 = 5;
  localparam int REGC_L1 = 6;

  typedef struct packed {
    logic [NL-1:0] dir;
    logic [NL-1:0] dout;
    logic [NL-1:0] pen;
    logic [NL-1:0] psel;
    logic [NL-1:0] od;
    logic [NL-1:0] ren;
    logic [NL-1:0] fen;
    logic [NL-1:0] mask;
    logic [NL-1:0] sec;
    logic [NL-1:0] apen;
    logic [NL-1:0] apsel;
    logic [NL-1:0] aod;
    logic [2:0]    route;
  } cfg_t;
endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_in,
  input  logic primary,
  output logic synced,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic prev;
  logic prim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      prev   <= 1'b0;
      prim_q <= 1'b0;
    end else begin
      sh     <= {sh[STAGES-2:0], pad_in};
      prev   <= sh[STAGES-1];
      prim_q <= primary;
    end
  end

  assign synced = sh[STAGES-1];
  // history is only trusted when the line was primary in the previous cycle too
  assign rise = primary & prim_q &  sh[STAGES-1] & ~prev;
  assign fall = primary & prim_q & ~sh[STAGES-1] &  prev;

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise) else $error("repeated rise");  // R3
  AST_FALL_ONCE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall) else $error("repeated fall");  // R3
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [NL-1:0]     din,
  input  logic [NL-1:0]     evt,
  output cfg_t              cfg,
  output logic [NL-1:0]     stat,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = NL - SEL_SPLIT;

  logic [NL-1:0] clr;
  assign clr = (we && addr == ADDR_W'(A_STAT)) ? wdata[NL-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      stat <= '0;
    end else begin
      stat <= (stat & ~clr) | evt;
      if (we) begin
        case (addr)
          ADDR_W'(A_DIR):   cfg.dir   <= wdata[NL-1:0];
          ADDR_W'(A_DOUT):  cfg.dout  <= wdata[NL-1:0];
          ADDR_W'(A_PEN):   cfg.pen   <= wdata[NL-1:0];
          ADDR_W'(A_PSEL):  cfg.psel  <= wdata[NL-1:0];
          ADDR_W'(A_OD):    cfg.od    <= wdata[NL-1:0];
          ADDR_W'(A_REN):   cfg.ren   <= wdata[NL-1:0];
          ADDR_W'(A_FEN):   cfg.fen   <= wdata[NL-1:0];
          ADDR_W'(A_MASK):  cfg.mask  <= wdata[NL-1:0];
          ADDR_W'(A_SELLO): cfg.sec[SEL_SPLIT-1:0] <= wdata[SEL_SPLIT-1:0];
          ADDR_W'(A_SELHI): cfg.sec[NL-1:SEL_SPLIT] <= wdata[HI_W-1:0];
          ADDR_W'(A_APEN):  cfg.apen  <= wdata[NL-1:0];
          ADDR_W'(A_APSEL): cfg.apsel <= wdata[NL-1:0];
          ADDR_W'(A_AOD):   cfg.aod   <= wdata[NL-1:0];
          ADDR_W'(A_ROUTE): cfg.route <= wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_W'(A_DIR):   rdata <= DATA_W'(cfg.dir);
        ADDR_W'(A_DOUT):  rdata <= DATA_W'(cfg.dout);
        ADDR_W'(A_DIN):   rdata <= DATA_W'(din);
        ADDR_W'(A_PEN):   rdata <= DATA_W'(cfg.pen);
        ADDR_W'(A_PSEL):  rdata <= DATA_W'(cfg.psel);
        ADDR_W'(A_OD):    rdata <= DATA_W'(cfg.od);
        ADDR_W'(A_REN):   rdata <= DATA_W'(cfg.ren);
        ADDR_W'(A_FEN):   rdata <= DATA_W'(cfg.fen);
        ADDR_W'(A_MASK):  rdata <= DATA_W'(cfg.mask);
        ADDR_W'(A_STAT):  rdata <= DATA_W'(stat);
        ADDR_W'(A_SELLO): rdata <= DATA_W'(cfg.sec[SEL_SPLIT-1:0]);
        ADDR_W'(A_SELHI): rdata <= DATA_W'(cfg.sec[NL-1:SEL_SPLIT]);
        ADDR_W'(A_APEN):  rdata <= DATA_W'(cfg.apen);
        ADDR_W'(A_APSEL): rdata <= DATA_W'(cfg.apsel);
        ADDR_W'(A_AOD):   rdata <= DATA_W'(cfg.aod);
        ADDR_W'(A_ROUTE): rdata <= DATA_W'(cfg.route);
        default:          rdata <= '0;
      endcase
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_stat_chk
    AST_STAT_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
      (!$past(evt[i]) && !$past(stat[i])) |-> !stat[i])
      else $error("status set without event");  // R5
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg,
  input  logic [NL-1:0] alt_out,
  input  logic [NL-1:0] alt_oe,
  input  logic          regen_a,
  input  logic          regen_b,
  input  logic          regen_c,
  output logic [NL-1:0] pad_o,
  output logic [NL-1:0] pad_oe,
  output logic [NL-1:0] pad_pu,
  output logic [NL-1:0] pad_pd
);
  logic [NL-1:0] rg_sel;
  logic [NL-1:0] rg_val;

  for (genvar i = 0; i < NL; i++) begin : g_route
    if (i == REGA_L0) begin : g_a0
      assign rg_sel[i] = ~cfg.route[0];
      assign rg_val[i] = regen_a;
    end else if (i == REGA_L1) begin : g_a1
      assign rg_sel[i] = cfg.route[0];
      assign rg_val[i] = regen_a;
    end else if (i == REGB_L) begin : g_b
      assign rg_sel[i] = cfg.route[2];
      assign rg_val[i] = regen_b;
    end else if (i == REGC_L0) begin : g_c0
      assign rg_sel[i] = ~cfg.route[1];
      assign rg_val[i] = regen_c;
    end else if (i == REGC_L1) begin : g_c1
      assign rg_sel[i] = cfg.route[1];
      assign rg_val[i] = regen_c;
    end else begin : g_none
      assign rg_sel[i] = 1'b0;
      assign rg_val[i] = 1'b0;
    end
  end

  logic [NL-1:0] val, req, odm, pe, ps;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      if (cfg.sec[i]) begin
        val[i] = rg_sel[i] ? rg_val[i] : alt_out[i];
        req[i] = rg_sel[i] ? 1'b1      : alt_oe[i];
        odm[i] = cfg.aod[i];
        pe[i]  = cfg.apen[i];
        ps[i]  = cfg.apsel[i];
      end else begin
        val[i] = cfg.dout[i];
        req[i] = cfg.dir[i];
        odm[i] = cfg.od[i];
        pe[i]  = cfg.pen[i];
        ps[i]  = cfg.psel[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= '0;
      pad_oe <= '0;
      pad_pu <= '0;
      pad_pd <= '0;
    end else begin
      pad_o  <= req & ~odm & val;
      pad_oe <= req & (~odm | ~val);
      pad_pu <= pe & ps;
      pad_pd <= pe & ~ps;
    end
  end

  AST_REGEN_A_LINE0: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.sec[REGA_L0] && !cfg.route[0] && !cfg.aod[REGA_L0])
    |-> (pad_o[REGA_L0] == $past(regen_a)) && pad_oe[REGA_L0])
    else $error("regulator A not on line 0");  // R9
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NL-1:0]     pad_i,
  output logic [NL-1:0]     pad_o,
  output logic [NL-1:0]     pad_oe,
  output logic [NL-1:0]     pad_pu,
  output logic [NL-1:0]     pad_pd,
  input  logic [NL-1:0]     alt_out_i,
  input  logic [NL-1:0]     alt_oe_i,
  output logic [NL-1:0]     alt_in_o,
  input  logic              regen_a_i,
  input  logic              regen_b_i,
  input  logic              regen_c_i,
  input  logic              dev_off_i,
  output logic              irq_o,
  output logic              wake_o
);
  cfg_t          cfg;
  logic [NL-1:0] stat, synced, rise, fall, evt;

  for (genvar i = 0; i < NL; i++) begin : g_line
    gpio_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .pad_in  (pad_i[i]),
      .primary (~cfg.sec[i]),
      .synced  (synced[i]),
      .rise    (rise[i]),
      .fall    (fall[i])
    );
  end

  assign evt = (rise & cfg.ren) | (fall & cfg.fen);

  gpio_bank_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .we    (reg_we),
    .din   (synced),
    .evt   (evt),
    .cfg   (cfg),
    .stat  (stat),
    .rdata (reg_rdata)
  );

  gpio_pad_mux u_mux (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .alt_out (alt_out_i),
    .alt_oe  (alt_oe_i),
    .regen_a (regen_a_i),
    .regen_b (regen_b_i),
    .regen_c (regen_c_i),
    .pad_o   (pad_o),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu),
    .pad_pd  (pad_pd)
  );

  assign alt_in_o = synced & cfg.sec;

  logic [NL-1:0] wake_allow;
  assign wake_allow = dev_off_i ? ~WAKE_EXCL : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= |(stat & ~cfg.mask);
      wake_o <= |(evt & wake_allow);
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(&cfg.mask) |-> !irq_o) else $error("irq while fully masked");  // R6
  AST_NO_STAT_ALT: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~$past(stat)) & $past(cfg.sec)) == '0)
    else $error("status raised on alternate line");  // R10
  AST_OFF_WAKE_SRC: assert property (@(posedge clk) disable iff (rst)
    ($past(dev_off_i) && wake_o) |-> $past(|(evt & ~WAKE_EXCL)))
    else $error("wake from excluded line while off");  // R11
endmodule

// File: tb/gpio_mux_bank_test.sv
module gpio_mux_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic [6:0] pad_i = '0, pad_o, pad_oe, pad_pu, pad_pd;
  logic [6:0] alt_out_i = '0, alt_oe_i = '0, alt_in_o;
  logic       regen_a_i = 0, regen_b_i = 0, regen_c_i = 0, dev_off_i = 0;
  logic       irq_o, wake_o;
  int         runs = 0, fails = 0, wcnt = 0;

  always #4 clk = ~clk;

  gpio_mux_bank uut (.*);

  always @(posedge clk) if (!rst && wake_o) wcnt++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  function automatic logic [13:0] drive(input logic [6:0] v, input logic [6:0] r,
                                        input logic [6:0] od);
    return {r & ~od & v, r & (~od | ~v)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    logic [7:0] d;
    logic [13:0] e;
    int w0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    waitc(2);
    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(5'(a), d);
      chk("R1 reg reset", d, 0);
    end
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pulls", {pad_pu, pad_pd}, 0);
    chk("R1 irq/wake", {irq_o, wake_o}, 0);

    // R2: read/write of every mapped register, unmapped decode
    for (int a = 0; a < 16; a++) begin
      if (a == 2 || a == 9 || a == 10 || a == 11 || a == 15) continue;
      wr(5'(a), 8'hFF ^ 8'(a));
      rd(5'(a), d);
      chk("R2 readback", d, (8'hFF ^ 8'(a)) & 8'h7F);
      wr(5'(a), 8'h00);
    end
    wr(5'h0A, 8'hFF); rd(5'h0A, d); chk("R2 padsel lo", d, 8'h0F);
    wr(5'h0B, 8'hFF); rd(5'h0B, d); chk("R2 padsel hi", d, 8'h07);
    wr(5'h0A, 0); wr(5'h0B, 0);
    wr(5'h0F, 8'hFF); rd(5'h0F, d); chk("R2 route", d, 8'h07);
    wr(5'h0F, 0);
    for (int a = 16; a < 32; a++) begin
      wr(5'(a), 8'hFF);
      rd(5'(a), d);
      chk("R2 unmapped read", d, 0);
    end
    for (int a = 0; a < 16; a++) begin
      rd(5'(a), d);
      chk("R2 unmapped write ignored", d, 0);
    end

    // R3/R4/R5/R6/R11: sweep of lines and trigger modes
    for (int ln = 0; ln < 7; ln++) begin
      for (int m = 0; m < 4; m++) begin
        wr(5'h06, m[0] ? 8'(1 << ln) : 8'h00);
        wr(5'h07, m[1] ? 8'(1 << ln) : 8'h00);
        w0 = wcnt;
        pad_i[ln] = 1'b1;
        waitc(6);
        rd(5'h02, d); chk("R3 din high", d, 8'(1 << ln));
        rd(5'h09, d); chk("R4 rise status", d, m[0] ? 8'(1 << ln) : 8'h00);
        chk("R6 irq on rise", irq_o, m[0]);
        chk("R11 wake per rise", wcnt - w0, m[0]);
        wr(5'h09, 8'h7F);
        w0 = wcnt;
        pad_i[ln] = 1'b0;
        waitc(6);
        rd(5'h09, d); chk("R4 fall status", d, m[1] ? 8'(1 << ln) : 8'h00);
        chk("R3 one event per fall", wcnt - w0, m[1]);
        wr(5'h09, 8'h7F);
        waitc(2);
        chk("R5 cleared irq", irq_o, 0);
      end
    end

    // R5/R6: sticky, selective clear, mask
    wr(5'h06, 8'h7F); wr(5'h08, 8'h02);
    pad_i = 7'b0000011; waitc(6);
    pad_i = 7'b0000000; waitc(6);
    rd(5'h09, d); chk("R5 sticky after input drop", d, 8'h03);
    wr(5'h09, 8'h01); rd(5'h09, d); chk("R5 write-1 clears only", d, 8'h02);
    waitc(2); chk("R6 masked bit quiet", irq_o, 0);
    wr(5'h08, 8'h00); waitc(2); chk("R6 unmask raises irq", irq_o, 1);
    wr(5'h09, 8'h7F); wr(5'h06, 0);

    // R7: primary drive
    wr(5'h00, 8'h55); wr(5'h01, 8'h33); wr(5'h05, 8'h0F);
    wr(5'h03, 8'h3C); wr(5'h04, 8'h0A); waitc(2);
    e = drive(7'h33, 7'h55, 7'h0F);
    chk("R7 pad_o", pad_o, e[13:7]); chk("R7 pad_oe", pad_oe, e[6:0]);
    chk("R7 pull up", pad_pu, 7'h08); chk("R7 pull down", pad_pd, 7'h34);

    // R8: alternate mode, default routing (A on 0, C on 5)
    alt_out_i = 7'h5A; alt_oe_i = 7'h6C; regen_a_i = 1; regen_c_i = 0;
    wr(5'h0C, 8'h41); wr(5'h0D, 8'h01); wr(5'h0E, 8'h02);
    wr(5'h0A, 8'h0F); wr(5'h0B, 8'h07); waitc(2);
    e = drive({1'b1, 1'b0, 5'b11010} & 7'h7F | 7'h00, 7'h00, 7'h00);
    e = drive({alt_out_i[6], 1'b0, alt_out_i[4:1], 1'b1},
              {alt_oe_i[6], 1'b1, alt_oe_i[4:1], 1'b1}, 7'h02);
    chk("R8 alt pad_o", pad_o, e[13:7]); chk("R8 alt pad_oe", pad_oe, e[6:0]);
    chk("R8 alt pulls", {pad_pu, pad_pd}, {7'h01, 7'h40});
    pad_i = 7'h29; waitc(5);
    chk("R8 alt_in", alt_in_o, 7'h29);

    // R9: alternate routing A on 3, C on 6, B on 4
    wr(5'h0E, 0); wr(5'h0F, 8'h07);
    regen_a_i = 1; regen_b_i = 0; regen_c_i = 1; waitc(2);
    e = drive({1'b1, alt_out_i[5], 1'b0, 1'b1, alt_out_i[2:0]},
              {1'b1, alt_oe_i[5], 1'b1, 1'b1, alt_oe_i[2:0]}, 0);
    chk("R9 routed pad_o", pad_o, e[13:7]); chk("R9 routed pad_oe", pad_oe, e[6:0]);

    // R10: no events in alternate, no false edge on return
    wr(5'h06, 8'h7F); wr(5'h07, 8'h7F); wr(5'h09, 8'h7F);
    w0 = wcnt;
    pad_i = 7'h56; waitc(6); pad_i = 7'h7F; waitc(6);
    rd(5'h09, d); chk("R10 no status in alternate", d, 0);
    wr(5'h0A, 0); wr(5'h0B, 0); waitc(6);
    rd(5'h09, d); chk("R10 no false edge on switch", d, 0);
    chk("R10 no wake", wcnt - w0, 0);
    pad_i = 0; waitc(6);
    rd(5'h09, d); chk("R10 edges resume", d, 8'h7F);
    wr(5'h09, 8'h7F);

    // R11: off-state exclusion
    dev_off_i = 1; w0 = wcnt;
    pad_i = 7'h04; waitc(6); pad_i = 0; waitc(6);
    pad_i = 7'h10; waitc(6); pad_i = 0; waitc(6);
    chk("R11 lines 2,4 no wake when off", wcnt - w0, 0);
    rd(5'h09, d); chk("R11 status still set", d, 8'h14);
    w0 = wcnt; pad_i = 7'h08; waitc(6);
    chk("R11 line 3 wakes when off", wcnt - w0, 1);
    dev_off_i = 0; w0 = wcnt; pad_i = 7'h0C; waitc(6);
    chk("R11 line 2 wakes when on", wcnt - w0, 1);

    done();
  end
endmodule